// File: doc/BRIEF.md
# D-PHY Data Lane Burst Sequencer

This block is the transmit-side controller for a group of high-speed serial data lanes. A byte stream arrives over a valid/ready interface. Once the clock lane reports that it is ready, every active lane runs the same line-state sequence. The lane leaves the low-power stop state through a request and bridge phase and drives the high-speed zero level. It then sends a sync byte followed by its share of the payload. After the payload it drives an inverted trail level, optionally releases the line before the end-of-transmission interval closes, and returns to stop. A one-cycle pulse tells the clock lane that the data lanes have finished their trail, so the clock lane can start its post interval.

Payload bytes are spread over the active lanes round-robin, starting at lane 0. The lanes advance together in beats. A beat appears on all lanes in the cycle after its last byte is taken. All phase lengths are given in clock cycles on configuration inputs, which are held steady while a burst runs. The lane count is sampled when a burst starts.

Top module: `dphy_burst_seq`

## Requirements
- R1: After reset and while idle, every lane drives stop (lp_p=1, lp_n=1) with hs_en=0 and hs_stb=0, and s_ready=0 and data_done=0.
- R2: A burst starts only on a clock edge where s_valid and clock_ready are both high. While clock_ready is low, every lane stays in stop.
- R3: Each active lane drives LP-01 (lp_p=0, lp_n=1) for max(cfg_lpx,1) cycles, then LP-00 for max(cfg_prepare,1) cycles, then high-speed with hs_data=8'h00 for max(cfg_zero,1) cycles. During any high-speed phase, lp_p=lp_n=0.
- R4: After the zero phase, every active lane presents 8'hB8 with hs_stb=1 for exactly one cycle, and the payload phase follows at once.
- R5: In the payload phase, s_ready is high until the byte marked s_last has been taken, one byte per cycle. Byte i goes to lane i mod N, where N is lane_count clamped to 1..NUM_LANES (0 counts as 1). Each beat is shown with hs_stb on its lanes in the cycle after its last byte is taken. Lanes without a strobe keep their previous byte.
- R6: Lanes numbered N and above stay in stop with hs_en=0 for the whole burst.
- R7: Lanes that receive no byte in the final beat stay high-speed without a strobe. All active lanes enter trail together, in the cycle after the final beat.
- R8: In trail, every bit of a lane's hs_data is the inverse of bit 7 of the last byte sent on that lane, the sync byte included. Bit 7 is the last one serialized. Trail lasts max(cfg_trail,1) cycles.
- R9: After trail, active lanes drive LP-00 with hs_en=0 for cfg_eot - max(cfg_trail,1) cycles when that is positive, and for zero cycles otherwise.
- R10: Active lanes then drive stop for max(cfg_exit,1) cycles before the block returns to idle.
- R11: data_done is high for exactly one cycle, the first cycle after trail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lpx | input | TW | Request (LP-01) length in cycles |
| cfg_prepare | input | TW | Bridge (LP-00) length in cycles |
| cfg_zero | input | TW | High-speed zero length in cycles |
| cfg_trail | input | TW | Trail length in cycles |
| cfg_eot | input | TW | Trail start to stop interval in cycles |
| cfg_exit | input | TW | Stop hold after a burst in cycles |
| lane_count | input | LC_W | Requested active lane count |
| clock_ready | input | 1 | Clock lane is running high-speed |
| s_valid | input | 1 | Payload byte valid |
| s_data | input | 8 | Payload byte |
| s_last | input | 1 | Marks the final payload byte |
| s_ready | output | 1 | Payload byte taken this cycle when valid |
| data_done | output | 1 | Trail finished, clock lane may start post |
| lane_lp_p | output | NUM_LANES | Low-power positive line level per lane |
| lane_lp_n | output | NUM_LANES | Low-power negative line level per lane |
| lane_hs_en | output | NUM_LANES | High-speed driver enable per lane |
| lane_hs_stb | output | NUM_LANES | New byte presented per lane |
| lane_hs_data | output | 8*NUM_LANES | High-speed byte per lane, lane 0 in the low byte |

## Verification
Some rules are checked by assertions on every cycle. No lane drives low-power levels while high-speed is enabled, and lanes outside the active count never leave stop. Beat strobes always fill lanes from lane 0 upward. The sync cycle always leads into payload, trail is entered only from payload, and the done pulse follows trail. No burst starts while the clock lane is not ready. Other behaviour only the bench scenarios show, because it needs a model of the whole burst: the exact length of every phase, the round-robin byte placement and its partial final beat, the trail polarity per lane, and the clamping of the end-of-transmission pad when it is shorter than the trail.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_REQ,
        PH_BRIDGE,
        PH_ZERO,
        PH_SYNC,
        PH_DATA,
        PH_TRAIL,
        PH_EOT,
        PH_EXIT
    } phase_e;

    typedef struct packed {
        logic       lp_p;
        logic       lp_n;
        logic       hs_en;
        logic       hs_stb;
        logic [7:0] data;
    } lane_out_t;

    localparam logic [7:0] SYNC_BYTE = 8'hB8;

    // Clamp a requested lane count into 1..max_lanes
    function automatic int unsigned eff_lanes(input int unsigned req, input int unsigned max_lanes);
        if (req == 0)
            return 1;
        if (req > max_lanes)
            return max_lanes;
        return req;
    endfunction

endpackage

// File: rtl/dphy_seq_ctrl.sv
module dphy_seq_ctrl
    import dphy_seq_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int TW        = 8,
    parameter int LC_W      = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TW-1:0]   cfg_lpx,
    input  logic [TW-1:0]   cfg_prepare,
    input  logic [TW-1:0]   cfg_zero,
    input  logic [TW-1:0]   cfg_trail,
    input  logic [TW-1:0]   cfg_eot,
    input  logic [TW-1:0]   cfg_exit,
    input  logic [LC_W-1:0] lane_count,
    input  logic            clock_ready,
    input  logic            s_valid,
    input  logic            s_last,
    output logic            s_ready,
    output logic            accept,
    output phase_e          phase,
    output logic [LC_W-1:0] act,
    output logic            data_done
);

    phase_e          phase_q;
    logic [TW-1:0]   cnt_q;
    logic [LC_W-1:0] act_q;
    logic            last_seen_q;
    logic            done_q;
    logic [TW-1:0]   trail_len;
    logic            cnt_zero;

    function automatic logic [TW-1:0] len_m1(input logic [TW-1:0] v);
        return (v == '0) ? '0 : v - TW'(1);
    endfunction

    assign trail_len = (cfg_trail == '0) ? TW'(1) : cfg_trail;
    assign cnt_zero  = (cnt_q == '0);
    assign s_ready   = (phase_q == PH_DATA) && !last_seen_q;
    assign accept    = s_ready && s_valid;
    assign phase     = phase_q;
    assign act       = act_q;
    assign data_done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            cnt_q       <= '0;
            act_q       <= LC_W'(1);
            last_seen_q <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (phase_q != PH_DATA)
                last_seen_q <= 1'b0;
            else if (accept && s_last)
                last_seen_q <= 1'b1;

            case (phase_q)
                PH_IDLE: begin
                    if (s_valid && clock_ready) begin
                        phase_q <= PH_REQ;
                        cnt_q   <= len_m1(cfg_lpx);
                        act_q   <= LC_W'(eff_lanes(int'(lane_count), NUM_LANES));
                    end
                end
                PH_REQ: begin
                    if (cnt_zero) begin
                        phase_q <= PH_BRIDGE;
                        cnt_q   <= len_m1(cfg_prepare);
                    end else begin
                        cnt_q <= cnt_q - TW'(1);
                    end
                end
                PH_BRIDGE: begin
                    if (cnt_zero) begin
                        phase_q <= PH_ZERO;
                        cnt_q   <= len_m1(cfg_zero);
                    end else begin
                        cnt_q <= cnt_q - TW'(1);
                    end
                end
                PH_ZERO: begin
                    if (cnt_zero)
                        phase_q <= PH_SYNC;
                    else
                        cnt_q <= cnt_q - TW'(1);
                end
                PH_SYNC: begin
                    phase_q <= PH_DATA;
                end
                PH_DATA: begin
                    if (last_seen_q) begin
                        phase_q <= PH_TRAIL;
                        cnt_q   <= trail_len - TW'(1);
                    end
                end
                PH_TRAIL: begin
                    if (cnt_zero) begin
                        done_q <= 1'b1;
                        if (cfg_eot > trail_len) begin
                            phase_q <= PH_EOT;
                            cnt_q   <= cfg_eot - trail_len - TW'(1);
                        end else begin
                            phase_q <= PH_EXIT;
                            cnt_q   <= len_m1(cfg_exit);
                        end
                    end else begin
                        cnt_q <= cnt_q - TW'(1);
                    end
                end
                PH_EOT: begin
                    if (cnt_zero) begin
                        phase_q <= PH_EXIT;
                        cnt_q   <= len_m1(cfg_exit);
                    end else begin
                        cnt_q <= cnt_q - TW'(1);
                    end
                end
                PH_EXIT: begin
                    if (cnt_zero)
                        phase_q <= PH_IDLE;
                    else
                        cnt_q <= cnt_q - TW'(1);
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    AST_NO_START_NO_CLK: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !clock_ready) |=> phase_q == PH_IDLE); // R2
    AST_SYNC_THEN_DATA: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SYNC) |=> phase_q == PH_DATA); // R4
    AST_TRAIL_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_q == PH_TRAIL) |-> $past(phase_q) == PH_DATA); // R7
    AST_DONE_AFTER_TRAIL: assert property (@(posedge clk) disable iff (rst)
        data_done |-> ($past(phase_q) == PH_TRAIL && phase_q != PH_TRAIL)); // R11
    AST_EXIT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXIT) |=> (phase_q == PH_EXIT || phase_q == PH_IDLE)); // R10

endmodule

// File: rtl/dphy_lane_dist.sv
module dphy_lane_dist
    import dphy_seq_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int LC_W      = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  phase_e               phase,
    input  logic                 accept,
    input  logic [7:0]           s_data,
    input  logic                 s_last,
    input  logic [LC_W-1:0]      act,
    output logic [7:0]           byte_q [NUM_LANES],
    output logic [NUM_LANES-1:0] stb_q,
    output logic [NUM_LANES-1:0] lastbit_q,
    output logic [NUM_LANES-1:0] act_mask
);

    logic [7:0]      slot_q [NUM_LANES];
    logic [LC_W-1:0] ptr_q;
    logic            beat_done;

    assign beat_done = accept && (s_last || ptr_q == act - LC_W'(1));

    always_comb begin
        for (int l = 0; l < NUM_LANES; l++)
            act_mask[l] = (LC_W'(l) < act);
    end

    // Round-robin write pointer, restarted for every burst
    always_ff @(posedge clk) begin
        if (rst || phase != PH_DATA)
            ptr_q <= '0;
        else if (accept)
            ptr_q <= beat_done ? '0 : ptr_q + LC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < NUM_LANES; l++) begin
                slot_q[l]    <= '0;
                byte_q[l]    <= '0;
                stb_q[l]     <= 1'b0;
                lastbit_q[l] <= 1'b0;
            end
        end else begin
            for (int l = 0; l < NUM_LANES; l++) begin
                stb_q[l] <= 1'b0;
                if (phase == PH_ZERO) begin
                    byte_q[l]    <= SYNC_BYTE;
                    lastbit_q[l] <= SYNC_BYTE[7];
                end
                if (accept && ptr_q == LC_W'(l))
                    slot_q[l] <= s_data;
                if (beat_done && LC_W'(l) <= ptr_q) begin
                    stb_q[l] <= 1'b1;
                    if (ptr_q == LC_W'(l)) begin
                        byte_q[l]    <= s_data;
                        lastbit_q[l] <= s_data[7];
                    end else begin
                        byte_q[l]    <= slot_q[l];
                        lastbit_q[l] <= slot_q[l][7];
                    end
                end
            end
        end
    end

    AST_STB_FROM_LANE0: assert property (@(posedge clk) disable iff (rst)
        (|stb_q) |-> stb_q[0]); // R5
    AST_STB_IN_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (stb_q & ~act_mask) == '0); // R6

endmodule

// File: rtl/dphy_lane_drv.sv
module dphy_lane_drv
    import dphy_seq_pkg::*;
(
    input  phase_e     phase,
    input  logic       active,
    input  logic [7:0] byte_in,
    input  logic       stb_in,
    input  logic       lastbit,
    output lane_out_t  lo
);

    always_comb begin
        lo       = '0;
        lo.lp_p  = 1'b1;
        lo.lp_n  = 1'b1;
        if (active) begin
            case (phase)
                PH_REQ: begin
                    lo.lp_p = 1'b0;
                end
                PH_BRIDGE, PH_EOT: begin
                    lo.lp_p = 1'b0;
                    lo.lp_n = 1'b0;
                end
                PH_ZERO: begin
                    lo.lp_p  = 1'b0;
                    lo.lp_n  = 1'b0;
                    lo.hs_en = 1'b1;
                end
                PH_SYNC: begin
                    lo.lp_p   = 1'b0;
                    lo.lp_n   = 1'b0;
                    lo.hs_en  = 1'b1;
                    lo.hs_stb = 1'b1;
                    lo.data   = SYNC_BYTE;
                end
                PH_DATA: begin
                    lo.lp_p   = 1'b0;
                    lo.lp_n   = 1'b0;
                    lo.hs_en  = 1'b1;
                    lo.hs_stb = stb_in;
                    lo.data   = byte_in;
                end
                PH_TRAIL: begin
                    lo.lp_p  = 1'b0;
                    lo.lp_n  = 1'b0;
                    lo.hs_en = 1'b1;
                    lo.data  = {8{~lastbit}};
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dphy_burst_seq.sv
module dphy_burst_seq
    import dphy_seq_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int TW        = 8,
    parameter int LC_W      = $clog2(NUM_LANES) + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [TW-1:0]          cfg_lpx,
    input  logic [TW-1:0]          cfg_prepare,
    input  logic [TW-1:0]          cfg_zero,
    input  logic [TW-1:0]          cfg_trail,
    input  logic [TW-1:0]          cfg_eot,
    input  logic [TW-1:0]          cfg_exit,
    input  logic [LC_W-1:0]        lane_count,
    input  logic                   clock_ready,
    input  logic                   s_valid,
    input  logic [7:0]             s_data,
    input  logic                   s_last,
    output logic                   s_ready,
    output logic                   data_done,
    output logic [NUM_LANES-1:0]   lane_lp_p,
    output logic [NUM_LANES-1:0]   lane_lp_n,
    output logic [NUM_LANES-1:0]   lane_hs_en,
    output logic [NUM_LANES-1:0]   lane_hs_stb,
    output logic [8*NUM_LANES-1:0] lane_hs_data
);

    phase_e               phase;
    logic                 accept;
    logic [LC_W-1:0]      act;
    logic [7:0]           byte_q [NUM_LANES];
    logic [NUM_LANES-1:0] stb_q;
    logic [NUM_LANES-1:0] lastbit_q;
    logic [NUM_LANES-1:0] act_mask;

    dphy_seq_ctrl #(.NUM_LANES(NUM_LANES), .TW(TW), .LC_W(LC_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cfg_lpx     (cfg_lpx),
        .cfg_prepare (cfg_prepare),
        .cfg_zero    (cfg_zero),
        .cfg_trail   (cfg_trail),
        .cfg_eot     (cfg_eot),
        .cfg_exit    (cfg_exit),
        .lane_count  (lane_count),
        .clock_ready (clock_ready),
        .s_valid     (s_valid),
        .s_last      (s_last),
        .s_ready     (s_ready),
        .accept      (accept),
        .phase       (phase),
        .act         (act),
        .data_done   (data_done)
    );

    dphy_lane_dist #(.NUM_LANES(NUM_LANES), .LC_W(LC_W)) u_dist (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .accept    (accept),
        .s_data    (s_data),
        .s_last    (s_last),
        .act       (act),
        .byte_q    (byte_q),
        .stb_q     (stb_q),
        .lastbit_q (lastbit_q),
        .act_mask  (act_mask)
    );

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        lane_out_t lo;

        dphy_lane_drv u_drv (
            .phase   (phase),
            .active  (act_mask[l]),
            .byte_in (byte_q[l]),
            .stb_in  (stb_q[l]),
            .lastbit (lastbit_q[l]),
            .lo      (lo)
        );

        assign lane_lp_p[l]           = lo.lp_p;
        assign lane_lp_n[l]           = lo.lp_n;
        assign lane_hs_en[l]          = lo.hs_en;
        assign lane_hs_stb[l]         = lo.hs_stb;
        assign lane_hs_data[8*l +: 8] = lo.data;

        AST_HS_NO_LP: assert property (@(posedge clk) disable iff (rst)
            lane_hs_en[l] |-> (!lane_lp_p[l] && !lane_lp_n[l])); // R3
        AST_IDLE_LANE_STOP: assert property (@(posedge clk) disable iff (rst)
            !act_mask[l] |-> (lane_lp_p[l] && lane_lp_n[l] && !lane_hs_en[l])); // R6
    end

endmodule

// File: tb/tb_dphy_burst_seq.sv
module tb_dphy_burst_seq;

    localparam int NL   = 4;
    localparam int TW   = 8;
    localparam int LC_W = 3;

    localparam int P_IDLE = 0, P_REQ = 1, P_BRG = 2, P_ZERO = 3, P_SYNC = 4,
                   P_DATA = 5, P_TRAIL = 6, P_EOT = 7, P_EXIT = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [TW-1:0]   cfg_lpx = 1, cfg_prepare = 1, cfg_zero = 1;
    logic [TW-1:0]   cfg_trail = 1, cfg_eot = 1, cfg_exit = 1;
    logic [LC_W-1:0] lane_count = 4;
    logic            clock_ready = 1'b1;
    logic            s_valid = 1'b0;
    logic [7:0]      s_data = '0;
    logic            s_last = 1'b0;
    logic            s_ready, data_done;
    logic [NL-1:0]   lane_lp_p, lane_lp_n, lane_hs_en, lane_hs_stb;
    logic [8*NL-1:0] lane_hs_data;

    always #4 clk = ~clk;

    dphy_burst_seq #(.NUM_LANES(NL), .TW(TW), .LC_W(LC_W)) dut (
        .clk(clk), .rst(rst),
        .cfg_lpx(cfg_lpx), .cfg_prepare(cfg_prepare), .cfg_zero(cfg_zero),
        .cfg_trail(cfg_trail), .cfg_eot(cfg_eot), .cfg_exit(cfg_exit),
        .lane_count(lane_count), .clock_ready(clock_ready),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .data_done(data_done),
        .lane_lp_p(lane_lp_p), .lane_lp_n(lane_lp_n), .lane_hs_en(lane_hs_en),
        .lane_hs_stb(lane_hs_stb), .lane_hs_data(lane_hs_data)
    );

    typedef struct {
        logic [NL-1:0]   lpp;
        logic [NL-1:0]   lpn;
        logic [NL-1:0]   hse;
        logic [NL-1:0]   stb;
        logic [8*NL-1:0] dat;
        logic            rdy;
        logic            dn;
        string           tag;
    } rec_t;

    rec_t       expq [$];
    int         n_chk = 0;
    int         n_bad = 0;
    bit         ended = 0;
    int         act_b;
    logic [7:0] hold [NL];
    logic       lbit [NL];
    logic [7:0] pl [0:31];

    function automatic int lmin1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic add_rec(input int ph, input logic [NL-1:0] m, input logic rdy,
                           input logic dn, input string tag);
        rec_t r;
        r.lpp = '1; r.lpn = '1; r.hse = '0; r.stb = '0; r.dat = '0;
        r.rdy = rdy; r.dn = dn; r.tag = tag;
        for (int l = 0; l < NL; l++) begin
            if (l < act_b) begin
                case (ph)
                    P_REQ: r.lpp[l] = 1'b0;
                    P_BRG, P_EOT: begin r.lpp[l] = 1'b0; r.lpn[l] = 1'b0; end
                    P_ZERO: begin r.lpp[l] = 1'b0; r.lpn[l] = 1'b0; r.hse[l] = 1'b1; end
                    P_SYNC: begin
                        r.lpp[l] = 1'b0; r.lpn[l] = 1'b0; r.hse[l] = 1'b1;
                        r.stb[l] = 1'b1; r.dat[8*l +: 8] = 8'hB8;
                    end
                    P_DATA: begin
                        r.lpp[l] = 1'b0; r.lpn[l] = 1'b0; r.hse[l] = 1'b1;
                        r.stb[l] = m[l]; r.dat[8*l +: 8] = hold[l];
                    end
                    P_TRAIL: begin
                        r.lpp[l] = 1'b0; r.lpn[l] = 1'b0; r.hse[l] = 1'b1;
                        r.dat[8*l +: 8] = {8{~lbit[l]}};
                    end
                    default: ;
                endcase
            end
        end
        expq.push_back(r);
    endtask

    // Driver: builds the expected per-cycle trace, then feeds the bytes
    task automatic run_burst(input int pre, input int lpx, input int prep, input int zero,
                             input int trail, input int eot, input int ext,
                             input int lc, input int n);
        int lt, pad, idx;
        bit took, first;
        logic [NL-1:0] m;
        @(negedge clk);
        cfg_lpx = TW'(lpx); cfg_prepare = TW'(prep); cfg_zero = TW'(zero);
        cfg_trail = TW'(trail); cfg_eot = TW'(eot); cfg_exit = TW'(ext);
        lane_count = LC_W'(lc);
        act_b = (lc == 0) ? 1 : ((lc > NL) ? NL : lc);
        for (int k = 0; k < pre; k++) add_rec(P_IDLE, '0, 1'b0, 1'b0, "R2");
        for (int k = 0; k < lmin1(lpx); k++) add_rec(P_REQ, '0, 1'b0, 1'b0, "R3");
        for (int k = 0; k < lmin1(prep); k++) add_rec(P_BRG, '0, 1'b0, 1'b0, "R3");
        for (int k = 0; k < lmin1(zero); k++) add_rec(P_ZERO, '0, 1'b0, 1'b0, "R3");
        for (int l = 0; l < NL; l++) begin hold[l] = 8'hB8; lbit[l] = 1'b1; end
        add_rec(P_SYNC, '0, 1'b0, 1'b0, "R4");
        for (int c = 0; c <= n; c++) begin
            m = '0;
            if (c > 0) begin
                int e, b;
                e = c - 1;
                if ((e % act_b) == act_b - 1 || e == n - 1) begin
                    b = e / act_b;
                    for (int l = 0; l < act_b; l++) begin
                        if (b * act_b + l <= n - 1) begin
                            m[l] = 1'b1;
                            hold[l] = pl[b * act_b + l];
                            lbit[l] = pl[b * act_b + l][7];
                        end
                    end
                end
            end
            add_rec(P_DATA, m, (c < n), 1'b0, "R5 R6");
        end
        lt = lmin1(trail);
        pad = (eot > lt) ? eot - lt : 0;
        for (int k = 0; k < lt; k++) add_rec(P_TRAIL, '0, 1'b0, 1'b0, "R7 R8");
        first = 1;
        for (int k = 0; k < pad; k++) begin
            add_rec(P_EOT, '0, 1'b0, first, first ? "R11 R9" : "R9");
            first = 0;
        end
        for (int k = 0; k < lmin1(ext); k++) begin
            add_rec(P_EXIT, '0, 1'b0, first, first ? "R11 R10" : "R10");
            first = 0;
        end
        add_rec(P_IDLE, '0, 1'b0, 1'b0, "R10");

        clock_ready = (pre == 0);
        s_valid = 1'b1; s_data = pl[0]; s_last = (n == 1);
        if (pre > 0) begin
            repeat (pre) @(negedge clk);
            clock_ready = 1'b1;
        end
        idx = 0;
        while (1) begin
            took = s_ready;
            @(negedge clk);
            if (took) begin
                idx++;
                if (idx == n) begin
                    s_valid = 1'b0; s_last = 1'b0;
                    break;
                end
                s_data = pl[idx]; s_last = (idx == n - 1);
            end
        end
        while (expq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: pops one expected record per cycle and compares
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (expq.size() != 0) begin
                rec_t r;
                r = expq.pop_front();
                n_chk++;
                if (lane_lp_p !== r.lpp || lane_lp_n !== r.lpn || lane_hs_en !== r.hse ||
                    lane_hs_stb !== r.stb || lane_hs_data !== r.dat ||
                    s_ready !== r.rdy || data_done !== r.dn) begin
                    n_bad++;
                    $display("FAIL %s: got lp=%b/%b hs=%b stb=%b dat=%h rdy=%b done=%b exp lp=%b/%b hs=%b stb=%b dat=%h rdy=%b done=%b",
                             r.tag, lane_lp_p, lane_lp_n, lane_hs_en, lane_hs_stb, lane_hs_data,
                             s_ready, data_done, r.lpp, r.lpn, r.hse, r.stb, r.dat, r.rdy, r.dn);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_bad++;
            $display("FAIL watchdog (R1..burst flow): got hung run, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) pl[i] = 8'((i * 71 + 19) ^ (i << 5));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        n_chk++;
        if (lane_lp_p !== '1 || lane_lp_n !== '1 || lane_hs_en !== '0 ||
            lane_hs_stb !== '0 || s_ready !== 1'b0 || data_done !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got lp=%b/%b hs=%b stb=%b rdy=%b done=%b exp lp=1111/1111 hs=0 stb=0 rdy=0 done=0",
                     lane_lp_p, lane_lp_n, lane_hs_en, lane_hs_stb, s_ready, data_done);
        end
        // four lanes, partial final beat, pad after trail
        run_burst(0, 2, 3, 2, 2, 5, 3, 4, 10);
        // two lanes, clock lane late, eot shorter than trail
        run_burst(4, 1, 2, 3, 3, 1, 2, 2, 5);
        // zero lane count clamps to one, all lengths zero
        for (int i = 0; i < 32; i++) pl[i] = 8'(i * 53 + 200);
        run_burst(0, 0, 0, 0, 0, 0, 0, 0, 3);
        // oversize lane count clamps to four, exact full beat
        run_burst(0, 1, 1, 1, 4, 6, 1, 7, 4);
        // three lanes, single byte: lanes 1 and 2 trail from sync
        run_burst(2, 3, 1, 2, 1, 4, 2, 3, 1);
        // R1: idle again after all bursts
        n_chk++;
        if (lane_lp_p !== '1 || lane_lp_n !== '1 || lane_hs_en !== '0 || data_done !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got lp=%b/%b hs=%b done=%b exp lp=1111/1111 hs=0 done=0",
                     lane_lp_p, lane_lp_n, lane_hs_en, data_done);
        end
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule